// File: doc/BRIEF.md
# Domain-Versioned Predictor Table

This block is a small direct-mapped table, suited to holding branch-predictor entries or cache tags, in which every slot stores a domain version next to its tag and payload. The version is the value of a global counter at the time the slot was written. A one-cycle switch strobe advances that counter. Every slot written under an older version then reads as a miss, so leaving a security domain never needs a walk over the table. Slots whose stored version has gone stale can never leak into the next domain.

A lookup presents an index and a tag and gets back a hit flag and the stored data in the same cycle. An update writes tag and data into the indexed slot. Because the counter is narrow, it can only be advanced a limited number of times. The switch that would wrap it back to zero instead sets it to zero and starts a physical sweep that clears one slot per cycle, with `busy` raised while the sweep runs. This stops a slot written long ago from matching again once the counter comes round.

Top module: `dvt_table`

## Requirements
- R1: After reset the version is 0, `busy` is low and every slot is invalid, so every lookup misses.
- R2: A lookup hits only when the indexed slot is valid, its stored tag equals `lk_tag` and its stored version equals the effective version of that cycle. `lk_data` shows the stored data on a hit and is 0 on a miss.
- R3: An accepted update stores tag, data and the effective version in slot `up_idx`, replacing what was there. Lookups see the new contents from the next cycle on.
- R4: A switch at a version below 2^VER_W-1 raises the version by one in a single cycle, whatever the table size. Every slot written before the switch then misses.
- R5: A lookup in the same cycle as a switch compares against the new version.
- R6: An update in the same cycle as a switch is recorded with the new version, so it hits after the switch.
- R7: A switch at version 2^VER_W-1 sets the version to 0 and holds `busy` high for exactly 2^IDX_W cycles, starting in the next cycle. In that switch cycle and while `busy` is high, lookups miss and updates and switches have no effect. Once the sweep ends, no slot written before the wrap hits.
- R8: A lookup and an update of the same slot in one cycle return the slot's contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_idx | input | IDX_W | Lookup slot index |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | DATA_W | Data of the hit slot, 0 on a miss |
| up_en | input | 1 | Update write enable |
| up_idx | input | IDX_W | Update slot index |
| up_tag | input | TAG_W | Update tag |
| up_data | input | DATA_W | Update data |
| dom_switch | input | 1 | Domain switch strobe |
| busy | output | 1 | Wrap sweep in progress |

## Verification
Directed sequences first fill every slot and then switch, which tells a per-slot clear apart from a true version bump. They place a switch in the same cycle as a lookup or an update, which tells old-version compares and writes from new-version ones. They also place a read and a write on the same slot in one cycle, which separates read-before-write from write-through. The counter is driven right up to its wrap, with updates and switches issued during the sweep. This tells a correct sweep from a missing one, from a sweep of the wrong length and from one that leaks inputs given while busy. A long random stream then mixes lookups, updates and sparse switches over a narrow tag range so that hits and misses both occur often. Every cycle is compared against a bench model of the table.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SWEEP = 1'b1
    } dvt_mode_e;
endpackage

// File: rtl/dvt_version_ctrl.sv
module dvt_version_ctrl #(
    parameter int IDX_W = 4,
    parameter int VER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dom_switch,
    output logic [VER_W-1:0] eff_ver,
    output logic             wrap_now,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    import dvt_pkg::*;

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [VER_W-1:0] VER_MAX  = {VER_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        dvt_mode_e        mode;
        logic [VER_W-1:0] ver;
        logic [IDX_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        eff_ver  = st_q.ver;
        wrap_now = 1'b0;
        clr_en   = 1'b0;
        clr_idx  = st_q.cnt;
        if (st_q.mode == MODE_RUN) begin
            if (dom_switch) begin
                eff_ver  = st_q.ver + VER_W'(1);
                st_d.ver = st_q.ver + VER_W'(1);
                if (st_q.ver == VER_MAX) begin
                    wrap_now  = 1'b1;
                    st_d.mode = MODE_SWEEP;
                    st_d.cnt  = '0;
                end
            end
        end else begin
            clr_en   = 1'b1;
            st_d.cnt = st_q.cnt + IDX_W'(1);
            if (st_q.cnt == IDX_LAST) begin
                st_d.mode = MODE_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RUN, ver: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.mode == MODE_SWEEP);

    // R4: a switch below the top value steps the version by one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dom_switch && st_q.ver != VER_MAX) |=> (st_q.ver == $past(st_q.ver) + VER_W'(1)));
    // R4, R7: without an accepted switch the version holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(dom_switch && !busy) |=> $stable(st_q.ver));
    // R7: the wrapping switch starts a sweep at version zero
    a_r7_wrap_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dom_switch && st_q.ver == VER_MAX) |=> (busy && st_q.ver == '0 && st_q.cnt == '0));
    // R7: the sweep ends only after the last slot
    a_r7_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st_q.cnt) == IDX_LAST));
endmodule

// File: rtl/dvt_entry_array.sv
module dvt_entry_array #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int VER_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [DATA_W-1:0] wdata,
    input  logic [VER_W-1:0]  wver,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  ridx,
    output logic              r_valid,
    output logic [TAG_W-1:0]  r_tag,
    output logic [DATA_W-1:0] r_data,
    output logic [VER_W-1:0]  r_ver
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic [VER_W-1:0]  ver;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t            slots [DEPTH];
    logic [DEPTH-1:0] vld;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_en && clr_idx == IDX_W'(i)) begin
                slot_d.valid = 1'b0;
            end else if (we && widx == IDX_W'(i)) begin
                slot_d = '{valid: 1'b1, ver: wver, tag: wtag, data: wdata};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slots[i] = slot_q;
        assign vld[i]   = slot_q.valid;
    end

    assign r_valid = slots[ridx].valid;
    assign r_tag   = slots[ridx].tag;
    assign r_data  = slots[ridx].data;
    assign r_ver   = slots[ridx].ver;

    // R3: a written slot is valid next cycle
    a_r3_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr_en) |=> vld[$past(widx)]);
    // R7: the sweep invalidates the slot it visits
    a_r7_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vld[$past(clr_idx)]);
    // R7: sweep and write never coincide
    a_r7_no_write_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && clr_en));
endmodule

// File: rtl/dvt_match.sv
module dvt_match #(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int VER_W  = 3
) (
    input  logic              enable,
    input  logic              r_valid,
    input  logic [TAG_W-1:0]  r_tag,
    input  logic [DATA_W-1:0] r_data,
    input  logic [VER_W-1:0]  r_ver,
    input  logic [TAG_W-1:0]  q_tag,
    input  logic [VER_W-1:0]  q_ver,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        hit  = enable && r_valid && (r_tag == q_tag) && (r_ver == q_ver);
        data = hit ? r_data : '0;
    end
endmodule

// File: rtl/dvt_table.sv
module dvt_table #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int VER_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [DATA_W-1:0] up_data,
    input  logic              dom_switch,
    output logic              busy
);
    logic [VER_W-1:0]  eff_ver;
    logic              wrap_now;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;
    logic              accept;
    logic              r_valid;
    logic [TAG_W-1:0]  r_tag;
    logic [DATA_W-1:0] r_data;
    logic [VER_W-1:0]  r_ver;

    dvt_version_ctrl #(.IDX_W(IDX_W), .VER_W(VER_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dom_switch (dom_switch),
        .eff_ver    (eff_ver),
        .wrap_now   (wrap_now),
        .busy       (busy),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );

    assign accept = !busy && !wrap_now;

    dvt_entry_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .VER_W(VER_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (up_en && accept),
        .widx    (up_idx),
        .wtag    (up_tag),
        .wdata   (up_data),
        .wver    (eff_ver),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .ridx    (lk_idx),
        .r_valid (r_valid),
        .r_tag   (r_tag),
        .r_data  (r_data),
        .r_ver   (r_ver)
    );

    dvt_match #(.TAG_W(TAG_W), .DATA_W(DATA_W), .VER_W(VER_W)) u_match (
        .enable  (accept),
        .r_valid (r_valid),
        .r_tag   (r_tag),
        .r_data  (r_data),
        .r_ver   (r_ver),
        .q_tag   (lk_tag),
        .q_ver   (eff_ver),
        .hit     (lk_hit),
        .data    (lk_data)
    );

    // R7: no hit during a sweep
    a_r7_no_hit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !busy);
    // R2: a miss returns zero data
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_data == '0));
    // R7: the wrap cycle never hits
    a_r7_wrap_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_switch && $rose(busy) == 1'b0 && !busy && wrap_now) |-> !lk_hit);
endmodule

// File: tb/dvt_table_tb.sv
module dvt_table_tb;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int VER_W  = 3;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int VMOD   = 1 << VER_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  lk_idx = '0;
    logic [TAG_W-1:0]  lk_tag = '0;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              up_en = 1'b0;
    logic [IDX_W-1:0]  up_idx = '0;
    logic [TAG_W-1:0]  up_tag = '0;
    logic [DATA_W-1:0] up_data = '0;
    logic              dom_switch = 1'b0;
    logic              busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of the table
    bit m_v   [DEPTH];
    int m_ver [DEPTH];
    int m_tag [DEPTH];
    int m_dat [DEPTH];
    int m_cur = 0;
    int m_left = 0;

    always #5 clk = ~clk;

    dvt_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .VER_W(VER_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .lk_data(lk_data), .up_en(up_en), .up_idx(up_idx), .up_tag(up_tag),
        .up_data(up_data), .dom_switch(dom_switch), .busy(busy)
    );

    function automatic bit m_wrap(bit sw);
        return (m_left == 0) && sw && (m_cur == VMOD - 1);
    endfunction

    function automatic int m_eff(bit sw);
        return (sw && m_left == 0) ? (m_cur + 1) % VMOD : m_cur;
    endfunction

    function automatic bit m_hit(bit sw, int li, int lt);
        if (m_left != 0 || m_wrap(sw)) return 1'b0;
        return m_v[li] && m_tag[li] == lt && m_ver[li] == m_eff(sw);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit sw, bit ue, int ui, int ut, int ud, int li, int lt, string req);
        bit eh;
        int ed;
        dom_switch = sw; up_en = ue;
        up_idx = IDX_W'(ui); up_tag = TAG_W'(ut); up_data = DATA_W'(ud);
        lk_idx = IDX_W'(li); lk_tag = TAG_W'(lt);
        #1;
        eh = m_hit(sw, li, lt);
        ed = eh ? m_dat[li] : 0;
        check(req, "busy", int'(busy), int'(m_left != 0));
        check(req, "hit", int'(lk_hit), int'(eh));
        check(req, "data", int'(lk_data), ed);
        @(posedge clk);
        if (m_left != 0) begin
            m_left--;
        end else if (m_wrap(sw)) begin
            for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
            m_cur = 0;
            m_left = DEPTH;
        end else begin
            if (ue) begin
                m_v[ui] = 1'b1; m_ver[ui] = m_eff(sw); m_tag[ui] = ut; m_dat[ui] = ud;
            end
            m_cur = m_eff(sw);
        end
        @(negedge clk);
    endtask

    task automatic idle_look(int li, int lt, string req);
        step(1'b0, 1'b0, 0, 0, 0, li, lt, req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_0017;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_ver[i] = 0; m_tag[i] = 0; m_dat[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset
        for (int i = 0; i < 4; i++) idle_look(i, 0, "R1");

        // R3: write then hit, then overwrite
        step(1'b0, 1'b1, 3, 5, 16'h1234, 0, 0, "R3");
        idle_look(3, 5, "R3");
        step(1'b0, 1'b1, 3, 6, 16'h0abc, 0, 0, "R3");
        idle_look(3, 5, "R3");
        idle_look(3, 6, "R3");

        // R8: read and write of one slot in one cycle
        step(1'b0, 1'b1, 3, 7, 16'h7777, 3, 6, "R8");
        idle_look(3, 7, "R8");

        // R4: full table then a switch
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, i, i + 1, i * 3 + 1, 0, 0, "R4");
        for (int i = 0; i < DEPTH; i++) idle_look(i, i + 1, "R4");
        step(1'b1, 1'b0, 0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < DEPTH; i++) idle_look(i, i + 1, "R4");

        // R5: lookup in the switch cycle
        step(1'b0, 1'b1, 9, 44, 900, 0, 0, "R5");
        idle_look(9, 44, "R5");
        step(1'b1, 1'b0, 0, 0, 0, 9, 44, "R5");

        // R6: update together with a switch
        step(1'b1, 1'b1, 10, 55, 1010, 0, 0, "R6");
        idle_look(10, 55, "R6");

        // R7: walk to the top version and wrap
        while (m_cur != VMOD - 1) step(1'b1, 1'b0, 0, 0, 0, 0, 0, "R7");
        step(1'b0, 1'b1, 2, 33, 222, 0, 0, "R7");
        idle_look(2, 33, "R7");
        step(1'b1, 1'b1, 4, 66, 444, 2, 33, "R7");
        for (int i = 0; i < DEPTH; i++) begin
            step(i[0], 1'b1, 5, 77, 555, 2, 33, "R7");
        end
        idle_look(2, 33, "R7");
        idle_look(4, 66, "R7");
        idle_look(5, 77, "R7");
        step(1'b0, 1'b1, 6, 88, 666, 0, 0, "R7");
        for (int i = 0; i < VMOD - 1; i++) step(1'b1, 1'b0, 0, 0, 0, 6, 88, "R7");
        step(1'b1, 1'b0, 0, 0, 0, 0, 0, "R7");
        idle_look(0, 0, "R7");

        // R2: random mix against the model
        for (int n = 0; n < 3000; n++) begin
            bit sw;
            bit ue;
            sw = ($urandom % 23) == 0;
            ue = ($urandom % 3) != 0;
            step(sw, ue, $urandom % DEPTH, $urandom % 4, $urandom % 65536,
                 $urandom % DEPTH, $urandom % 4, "R2");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule